// File: doc/BRIEF.md
# Zero Run Counter (leading / trailing)

This block counts the run of zero bits at one end of a 64-bit operand. A direction input chooses the end: when set, the run is counted upward from bit 0 (trailing zeros); when clear, it is counted downward from the most significant examined bit (leading zeros). A width input narrows the operation to the low 32 bits of the operand. In that mode the upper half has no influence on the result.

The count is found with a single lowest-set-bit encoder. For the leading direction the examined bits are mirrored before they reach the encoder, so the same encoder serves both directions. In narrow mode a sentinel one is placed just above bit 31, so an all-zero low half encodes as 32 without a separate zero test. The count is zero-extended to 64 bits and registered once. A valid flag follows the operation-select input by the same single cycle.

Top module: `zrun_count_unit`

## Requirements
- R1: With trail_dir=1 and narrow=0, one cycle after op_sel=1 the result equals the index of the lowest set bit of operand[63:0].
- R2: With trail_dir=0 and narrow=0, one cycle after op_sel=1 the result equals 63 minus the index of the highest set bit of operand[63:0].
- R3: With narrow=1, the result depends only on operand[31:0]: trailing counts upward from bit 0, and leading counts downward from bit 31.
- R4: An all-zero examined field gives 32 in narrow mode and 64 in full mode, in either direction.
- R5: In narrow mode the result never exceeds 32. In full mode it never exceeds 64.
- R6: result bits 63 down to 7 are always zero (the count is zero-extended).
- R7: result_vld equals op_sel delayed by exactly one clock.
- R8: While rst=1 (synchronous, active high), result is cleared to 0 and result_vld to 0 at the next clock.
- R9: A clock edge with op_sel=0 leaves result unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 1 | Perform the count this cycle |
| narrow | input | 1 | 1: examine operand[31:0] only |
| trail_dir | input | 1 | 1: trailing zeros, 0: leading zeros |
| operand | input | 64 | Value whose zero run is counted |
| result | output | 64 | Registered, zero-extended count |
| result_vld | output | 1 | Registered copy of op_sel |

## Verification
The bench aims at the extremes of the count: a set bit only at position 0 or at the top, and an all-zero operand. An encoder that fails to signal "no bit found" would return 0 instead of 32 or 64. A wrong mirror would swap the leading and trailing answers or be off by the width. Narrow-mode vectors place noise in the upper half, so a design that leaks operand[63:32] into the 32-bit count, or mirrors across 64 bits instead of 32, returns counts above 32 or counts that are simply wrong. Idle cycles with changing inputs expose a result register that does not hold its value.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic {
        DIR_LEAD  = 1'b0,
        DIR_TRAIL = 1'b1
    } zrun_dir_e;

    typedef struct packed {
        logic              narrow;
        zrun_dir_e         dir;
        logic [DATA_W-1:0] value;
    } zrun_req_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } zrun_cnt_t;

    function automatic logic [HALF_W-1:0] mirror_half(input logic [HALF_W-1:0] v);
        logic [HALF_W-1:0] r;
        for (int i = 0; i < HALF_W; i++) r[i] = v[HALF_W-1-i];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] mirror_full(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/zrun_prep.sv
module zrun_prep
    import zrun_pkg::*;
(
    input  zrun_req_t         req,
    output logic [DATA_W-1:0] enc_vec
);
    logic [HALF_W-1:0] low_field;
    logic [HALF_W-1:0] low_oriented;
    logic [DATA_W-1:0] full_oriented;
    logic [HALF_W-1:0] sentinel_half;

    assign low_field     = req.value[HALF_W-1:0];
    assign low_oriented  = (req.dir == DIR_TRAIL) ? low_field : mirror_half(low_field);
    assign full_oriented = (req.dir == DIR_TRAIL) ? req.value : mirror_full(req.value);
    assign sentinel_half = {{(HALF_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (req.narrow) enc_vec = {sentinel_half, low_oriented};
        else            enc_vec = full_oriented;
    end
endmodule

// File: rtl/zrun_lowest_one.sv
module zrun_lowest_one
    import zrun_pkg::*;
(
    input  logic [DATA_W-1:0] vec,
    output zrun_cnt_t         cnt
);
    logic [CNT_W-1:0] idx;
    logic             any_set;

    always_comb begin
        idx = CNT_W'(DATA_W);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (vec[i]) idx = CNT_W'(i);
        end
    end

    assign any_set   = |vec;
    assign cnt.count = idx;

    always_comb begin
        if (!any_set) a_empty_r4: assert (idx == CNT_W'(DATA_W));
    end
endmodule

// File: rtl/zrun_count_unit.sv
module zrun_count_unit
    import zrun_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_sel,
    input  logic          narrow,
    input  logic          trail_dir,
    input  logic [63:0]   operand,
    output logic [63:0]   result,
    output logic          result_vld
);
    zrun_req_t         req;
    logic [DATA_W-1:0] enc_vec;
    zrun_cnt_t         cnt;
    logic [CNT_W-1:0]  cnt_q;
    logic              vld_q;

    assign req.narrow = narrow;
    assign req.dir    = zrun_dir_e'(trail_dir);
    assign req.value  = operand;

    zrun_prep u_prep (
        .req     (req),
        .enc_vec (enc_vec)
    );

    zrun_lowest_one u_enc (
        .vec (enc_vec),
        .cnt (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_sel;
            if (op_sel) cnt_q <= cnt.count;
        end
    end

    assign result     = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
    assign result_vld = vld_q;

    p_zext_r6: assert property (@(posedge clk) disable iff (rst)
        result[63:CNT_W] == '0);
    p_narrow_range_r5: assert property (@(posedge clk) disable iff (rst)
        (op_sel && narrow) |=> (result <= 64'd32));
    p_full_range_r5: assert property (@(posedge clk) disable iff (rst)
        op_sel |=> (result <= 64'd64));
    p_vld_on_r7: assert property (@(posedge clk) disable iff (rst)
        op_sel |=> result_vld);
    p_vld_off_r7: assert property (@(posedge clk) disable iff (rst)
        !op_sel |=> !result_vld);
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !op_sel |=> $stable(result));
    p_narrow_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel && narrow && operand[31:0] == 32'd0) |=> (result == 64'd32));
    p_full_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel && !narrow && operand == 64'd0) |=> (result == 64'd64));
endmodule

// File: tb/test_zrun_count_unit.sv
module test_zrun_count_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_sel, narrow, trail_dir;
    logic [63:0] operand;
    logic [63:0] result;
    logic        result_vld;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] exp_res;
    logic        exp_vld;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    zrun_count_unit i_zrun_count_unit (
        .clk(clk), .rst(rst), .op_sel(op_sel), .narrow(narrow),
        .trail_dir(trail_dir), .operand(operand),
        .result(result), .result_vld(result_vld)
    );

    function automatic logic [63:0] ref_count(input logic nar, input logic tr, input logic [63:0] x);
        int w = nar ? 32 : 64;
        int n = 0;
        if (tr) begin
            for (int i = 0; i < w; i++) begin
                if (x[i]) break;
                n++;
            end
        end else begin
            for (int i = w - 1; i >= 0; i--) begin
                if (x[i]) break;
                n++;
            end
        end
        return 64'(n);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // drive one cycle (inputs change 1 ns after a rising edge), then check after the next edge
    task automatic step(input string tag, input logic s, input logic nar, input logic tr, input logic [63:0] x);
        op_sel = s; narrow = nar; trail_dir = tr; operand = x;
        if (s) exp_res = ref_count(nar, tr, x);
        exp_vld = s;
        @(posedge clk); #1;
        check(tag, result, exp_res);
        check("R7", 64'(result_vld), 64'(exp_vld));
        check("R6", 64'(result[63:7]), 64'd0);
    endtask

    initial begin
        rst = 1'b1; op_sel = 1'b1; narrow = 1'b0; trail_dir = 1'b1; operand = 64'hFFFF;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R8", result, 64'd0);
        check("R8", 64'(result_vld), 64'd0);
        rst = 1'b0; exp_res = 64'd0;

        // R1 full trailing
        step("R1", 1, 0, 1, 64'h1);
        step("R1", 1, 0, 1, 64'h8000_0000_0000_0000);
        step("R1", 1, 0, 1, 64'h0000_0100_0000_0000);
        step("R1", 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        // R2 full leading
        step("R2", 1, 0, 0, 64'h8000_0000_0000_0000);
        step("R2", 1, 0, 0, 64'h1);
        step("R2", 1, 0, 0, 64'h0000_0000_8000_0000);
        step("R2", 1, 0, 0, 64'h0000_7000_0000_0001);
        // R3 narrow with upper-half noise
        step("R3", 1, 1, 1, 64'hFFFF_FFFF_0000_0000);
        step("R3", 1, 1, 0, 64'hFFFF_FFFF_0000_0001);
        step("R3", 1, 1, 0, 64'hA5A5_0000_8000_0000);
        step("R3", 1, 1, 1, 64'h1234_5678_0000_0400);
        step("R3", 1, 1, 0, 64'hDEAD_BEEF_0001_0000);
        // R4 all-zero examined fields
        step("R4", 1, 0, 1, 64'h0);
        step("R4", 1, 0, 0, 64'h0);
        step("R4", 1, 1, 1, 64'h0);
        step("R4", 1, 1, 0, 64'hFFFF_FFFF_0000_0000);
        // R9 idle cycles with changing inputs hold the result
        step("R9", 0, 0, 1, 64'h1);
        step("R9", 0, 1, 0, 64'h0);
        step("R9", 1, 0, 1, 64'h10);
        step("R9", 0, 0, 0, 64'h0);
        // R5 mixed random sweep, sparse operands
        for (int k = 0; k < 400; k++) begin
            logic [63:0] x;
            logic nar, tr, s;
            x   = {$urandom, $urandom};
            x   = x & ({$urandom, $urandom} >> ($urandom % 64)) & ~({64{1'b1}} << ($urandom % 65));
            nar = 1'($urandom);
            tr  = 1'($urandom);
            s   = ($urandom % 4) != 0;
            step(nar ? "R5" : (tr ? "R1" : "R2"), s, nar, tr, x);
        end

        // R8 reset clears a nonzero result
        step("R1", 1, 0, 1, 64'h0);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R8", result, 64'd0);
        check("R8", 64'(result_vld), 64'd0);
        rst = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule